// File: doc/BRIEF.md
# Hypervisor translation control register file

This block holds the 64-bit translation control word of the hypervisor privilege level and the decoder that handles system-register move requests aimed at it. Each request carries the requester's privilege level, a five-part encoding (op0, op1, CRn, CRm, op2), a direction and write data. Several hypervisor control inputs go with it. The decoder settles each request in one cycle. The result is a read or write of the hypervisor word, a read or write of a stand-in guest word, a redirect to a memory-backed slot, a trap to the hypervisor, or an undefined-instruction result.

A host-mode input picks one of two field views of the stored word. The non-host view is narrow: only the low half is visible, and several fixed bits are forced. The host view is wide and covers two address ranges. In host mode, a hypervisor access that uses the lower-level alias encoding reaches the hypervisor word instead of the guest word. The block also drives effective control fields to the translation logic, with their gating rules already applied.

Top module: `hyp_xlat_ctl`

## Requirements
- R1: A request with op0=3, op1=4, CRn=2, CRm=0, op2=2 from level 2 or 3 reads or writes the hypervisor word. The response (`rsp_kind` bit 0 = read ok, bit 1 = write ok) appears on the first clock edge after the request.
- R2: Any request from level 0 gives the undefined result (`rsp_kind` bit 3).
- R3: A level-1 request using the hypervisor encoding traps (`rsp_kind` bit 2, `rsp_class` = 0x18) when `nest_bits[0]` is 1, and is undefined otherwise.
- R4: The alias encoding is the R1 encoding with op1=0. At level 2 with `host_mode`=1 it reaches the hypervisor word. At level 2 with `host_mode`=0, and at level 3, it reaches the guest word.
- R5: At level 1, an alias read traps with class 0x18 when `trap_vm_rd`=1, and an alias write traps when `trap_vm_wr`=1.
- R6: At level 1, `fg_trap_rd` and `fg_trap_wr` trap alias reads and alias writes, but only when `fg_enable`=1 or `monitor_present`=0.
- R7: At level 1 with `nest_bits`=3'b111, an alias access that does not trap gives the memory result (`rsp_kind` bit 4) with `rsp_mem_offset`=0x120. A write also reports its data. The guest word is left unchanged.
- R8: In the non-host view, reads and `cfg_view` show bits 31 and 23 as 1 and bits 63:32, 19, 7 and 6 as 0. A write in this view changes only bits 31:0.
- R9: In the host view, bits 63:59, 35 and 6 read as 0 and all other bits read as written. With `ASID8`=1, bit 36 also reads as 0.
- R10: The effective hardware-use bits are 0 whenever their range's hierarchy-disable bit is 0. In the host view these are bits 46:43 (gated by bit 41) and bits 50:47 (gated by bit 42). In the non-host view they are bits 28:25 (gated by bit 24). Effective dirty management is 1 only when the dirty bit and the access-flag bit are both 1 (host view bits 40 and 39, non-host view bits 22 and 21).
- R11: Every response has exactly one `rsp_kind` bit set. A trap or undefined result changes no stored word.
- R12: A request with any other encoding is undefined at every level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = move to register, 0 = move from register |
| req_level | input | 2 | Privilege level of the requester (0..3) |
| req_op0 | input | 2 | Encoding op0 |
| req_op1 | input | 3 | Encoding op1 |
| req_crn | input | 4 | Encoding CRn |
| req_crm | input | 4 | Encoding CRm |
| req_op2 | input | 3 | Encoding op2 |
| req_wdata | input | 64 | Write data |
| host_mode | input | 1 | Selects the host field view and alias redirection |
| nest_bits | input | 3 | Nested-virtualization controls; bit 0 enables traps |
| trap_vm_rd | input | 1 | Trap level-1 alias reads |
| trap_vm_wr | input | 1 | Trap level-1 alias writes |
| fg_trap_rd | input | 1 | Fine-grained read trap |
| fg_trap_wr | input | 1 | Fine-grained write trap |
| fg_enable | input | 1 | Enables the fine-grained traps |
| monitor_present | input | 1 | A secure monitor level exists |
| rsp_valid | output | 1 | Response present |
| rsp_kind | output | 5 | One-hot {mem, undef, trap, write ok, read ok} |
| rsp_rdata | output | 64 | Read data on a read-ok result, else 0 |
| rsp_class | output | 6 | Trap syndrome class, 0 when not a trap |
| rsp_mem_offset | output | 12 | Memory slot offset on a memory result |
| rsp_mem_write | output | 1 | Memory result is a write |
| rsp_mem_wdata | output | 64 | Write data of a memory write |
| cfg_view | output | 64 | Hypervisor word in the current view |
| eff_hwu_lo | output | 4 | Effective hardware-use bits, lower range |
| eff_hwu_hi | output | 4 | Effective hardware-use bits, upper range |
| eff_access | output | 1 | Effective access-flag update enable |
| eff_dirty | output | 1 | Effective dirty-state management enable |

## Verification
The bench checks the priority between outcomes. A trap must win over the memory redirect, and the fine-grained bits must trap only under their enable rule; a decoder that ordered these wrongly would send trapped accesses to memory or to the guest word. A trapped or undefined write is followed by a read-back, because a design that updated the register anyway would return the rejected data. The bench writes all-ones in each view, which exposes any forced or cleared bit that is missing. It also sets hardware-use and dirty bits while their gating bits are clear, so an ungated effective output would show 1.

// File: rtl/hxc_pkg.sv
package hxc_pkg;
    // Data width of the control word and of the guest stand-in.
    localparam int XW = 64;
    // Outcome bit positions inside the one-hot result.
    localparam int K_RD    = 0;
    localparam int K_WR    = 1;
    localparam int K_TRAP  = 2;
    localparam int K_UNDEF = 3;
    localparam int K_MEM   = 4;
    localparam int NK      = 5;
    // Privilege levels.
    localparam logic [1:0] LVL_USER  = 2'd0;
    localparam logic [1:0] LVL_GUEST = 2'd1;
    localparam logic [1:0] LVL_HYP   = 2'd2;
    // Encoding of the hypervisor word; the alias differs in op1 only.
    localparam logic [1:0] ENC_OP0     = 2'd3;
    localparam logic [2:0] ENC_OP1_HYP = 3'd4;
    localparam logic [2:0] ENC_OP1_ALI = 3'd0;
    localparam logic [3:0] ENC_CRN     = 4'd2;
    localparam logic [3:0] ENC_CRM     = 4'd0;
    localparam logic [2:0] ENC_OP2     = 3'd2;

    typedef enum logic [1:0] {
        TGT_NONE,
        TGT_HYP,
        TGT_GUEST,
        TGT_MEM
    } tgt_e;
endpackage

// File: rtl/hxc_access_decode.sv
// Access decoder: resolves one request into a one-hot outcome and a target.
// Assumes the request fields are stable during the cycle req_valid is high.
// Priority at level 1 alias: explicit traps, then memory redirect, then guest.
module hxc_access_decode
    import hxc_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          valid,
    input  logic          is_write,
    input  logic [1:0]    level,
    input  logic [1:0]    op0,
    input  logic [2:0]    op1,
    input  logic [3:0]    crn,
    input  logic [3:0]    crm,
    input  logic [2:0]    op2,
    input  logic          host_mode,
    input  logic [2:0]    nest_bits,
    input  logic          trap_vm_rd,
    input  logic          trap_vm_wr,
    input  logic          fg_trap_rd,
    input  logic          fg_trap_wr,
    input  logic          fg_enable,
    input  logic          monitor_present,
    output logic [NK-1:0] kind,
    output tgt_e          tgt
);
    logic common_hit, hyp_hit, ali_hit, vm_trap, fg_trap;

    // Match the encoding and evaluate the trap controls for this direction.
    always_comb begin
        common_hit = (op0 == ENC_OP0) && (crn == ENC_CRN) && (crm == ENC_CRM) && (op2 == ENC_OP2);
        hyp_hit    = common_hit && (op1 == ENC_OP1_HYP);
        ali_hit    = common_hit && (op1 == ENC_OP1_ALI);
        vm_trap    = is_write ? trap_vm_wr : trap_vm_rd;
        fg_trap    = (fg_enable || !monitor_present) && (is_write ? fg_trap_wr : fg_trap_rd);
    end

    // Choose the outcome and the target storage.
    always_comb begin
        kind = '0;
        tgt  = TGT_NONE;
        if (valid) begin
            if (level == LVL_USER || !(hyp_hit || ali_hit)) begin
                kind[K_UNDEF] = 1'b1;
            end else if (hyp_hit) begin
                if (level == LVL_GUEST) begin
                    if (nest_bits[0]) kind[K_TRAP]  = 1'b1;
                    else              kind[K_UNDEF] = 1'b1;
                end else begin
                    kind[K_WR] = is_write;
                    kind[K_RD] = !is_write;
                    tgt        = TGT_HYP;
                end
            end else if (level == LVL_GUEST) begin
                if (vm_trap || fg_trap) begin
                    kind[K_TRAP] = 1'b1;
                end else if (&nest_bits) begin
                    kind[K_MEM] = 1'b1;
                    tgt         = TGT_MEM;
                end else begin
                    kind[K_WR] = is_write;
                    kind[K_RD] = !is_write;
                    tgt        = TGT_GUEST;
                end
            end else begin
                kind[K_WR] = is_write;
                kind[K_RD] = !is_write;
                tgt        = (level == LVL_HYP && host_mode) ? TGT_HYP : TGT_GUEST;
            end
        end
    end

    a_r11_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> $countones(kind) == 1);
    a_r2_user_undef: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && level == LVL_USER) |-> kind[K_UNDEF]);
    a_r7_mem_needs_nest: assert property (@(posedge clk) disable iff (!rst_n)
        kind[K_MEM] |-> (&nest_bits) && level == LVL_GUEST);
endmodule

// File: rtl/hxc_view.sv
// Field view of the hypervisor word: read masking per view, write merging,
// and the gated effective fields for the translation logic. Combinational.
module hxc_view
    import hxc_pkg::*;
#(
    parameter bit ASID8 = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_mode,
    input  logic [XW-1:0] stored,
    input  logic [XW-1:0] wdata,
    output logic [XW-1:0] rd_view,
    output logic [XW-1:0] wr_next,
    output logic [3:0]    eff_hwu_lo,
    output logic [3:0]    eff_hwu_hi,
    output logic          eff_access,
    output logic          eff_dirty
);
    localparam int HW = XW / 2;
    localparam logic [HW-1:0] NH_ONES = (HW'(1) << 31) | (HW'(1) << 23);
    localparam logic [HW-1:0] NH_ZERO = (HW'(1) << 19) | (HW'(3) << 6);
    localparam logic [XW-1:0] HV_ZERO_BASE = (XW'(31) << 59) | (XW'(1) << 35) | (XW'(1) << 6);
    localparam logic [XW-1:0] HV_ZERO = ASID8 ? (HV_ZERO_BASE | (XW'(1) << 36)) : HV_ZERO_BASE;

    logic [HW-1:0] nh_low_rd, nh_low_wr;

    // Narrow-view low halves for read and write.
    always_comb begin
        nh_low_rd = (stored[HW-1:0] & ~NH_ZERO) | NH_ONES;
        nh_low_wr = (wdata[HW-1:0]  & ~NH_ZERO) | NH_ONES;
    end

    // Read view and merged write value for the selected view.
    always_comb begin
        if (host_mode) begin
            rd_view = stored & ~HV_ZERO;
            wr_next = wdata & ~HV_ZERO;
        end else begin
            rd_view = {{HW{1'b0}}, nh_low_rd};
            wr_next = {stored[XW-1:HW], nh_low_wr};
        end
    end

    // Effective fields with the hierarchy-disable and access-flag gating.
    always_comb begin
        if (host_mode) begin
            eff_hwu_lo = stored[46:43] & {4{stored[41]}};
            eff_hwu_hi = stored[50:47] & {4{stored[42]}};
            eff_access = stored[39];
            eff_dirty  = stored[40] & stored[39];
        end else begin
            eff_hwu_lo = stored[28:25] & {4{stored[24]}};
            eff_hwu_hi = 4'b0;
            eff_access = stored[21];
            eff_dirty  = stored[22] & stored[21];
        end
    end

    a_r8_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
        !host_mode |-> (rd_view[31] && rd_view[23] && rd_view[63:32] == '0 && !rd_view[19]));
    a_r9_host_zero: assert property (@(posedge clk) disable iff (!rst_n)
        host_mode |-> (rd_view[63:59] == '0 && !rd_view[35] && !rd_view[6]));
    a_r10_dirty_needs_access: assert property (@(posedge clk) disable iff (!rst_n)
        eff_dirty |-> eff_access);
    a_r10_hwu_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (host_mode && !stored[41]) |-> eff_hwu_lo == 4'b0);
endmodule

// File: rtl/hxc_regs.sv
// Storage: the hypervisor word and the guest stand-in word.
// Reset clears both; the reset contents carry no meaning for software.
module hxc_regs
    import hxc_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hyp_we,
    input  logic [XW-1:0] hyp_d,
    input  logic          guest_we,
    input  logic [XW-1:0] guest_d,
    output logic [XW-1:0] hyp_q,
    output logic [XW-1:0] guest_q
);
    // Hypervisor word update.
    always_ff @(posedge clk) begin
        if (!rst_n)      hyp_q <= '0;
        else if (hyp_we) hyp_q <= hyp_d;
    end

    // Guest stand-in update.
    always_ff @(posedge clk) begin
        if (!rst_n)        guest_q <= '0;
        else if (guest_we) guest_q <= guest_d;
    end
endmodule

// File: rtl/hyp_xlat_ctl.sv
// Top: hypervisor translation control word with its access decoder.
// Every request is answered one cycle later; stores happen on the same edge.
module hyp_xlat_ctl
    import hxc_pkg::*;
#(
    parameter bit          ASID8        = 1'b0,
    parameter logic [11:0] MEM_SLOT_OFF = 12'h120,
    parameter logic [5:0]  TRAP_CLASS   = 6'h18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [1:0]    req_level,
    input  logic [1:0]    req_op0,
    input  logic [2:0]    req_op1,
    input  logic [3:0]    req_crn,
    input  logic [3:0]    req_crm,
    input  logic [2:0]    req_op2,
    input  logic [63:0]   req_wdata,
    input  logic          host_mode,
    input  logic [2:0]    nest_bits,
    input  logic          trap_vm_rd,
    input  logic          trap_vm_wr,
    input  logic          fg_trap_rd,
    input  logic          fg_trap_wr,
    input  logic          fg_enable,
    input  logic          monitor_present,
    output logic          rsp_valid,
    output logic [4:0]    rsp_kind,
    output logic [63:0]   rsp_rdata,
    output logic [5:0]    rsp_class,
    output logic [11:0]   rsp_mem_offset,
    output logic          rsp_mem_write,
    output logic [63:0]   rsp_mem_wdata,
    output logic [63:0]   cfg_view,
    output logic [3:0]    eff_hwu_lo,
    output logic [3:0]    eff_hwu_hi,
    output logic          eff_access,
    output logic          eff_dirty
);
    logic [NK-1:0] kind;
    tgt_e          tgt;
    logic [XW-1:0] hyp_q, guest_q, rd_view, wr_next, rd_sel;
    logic          hyp_we, guest_we, mem_wr;

    hxc_access_decode dec_i (
        .clk(clk), .rst_n(rst_n), .valid(req_valid), .is_write(req_write),
        .level(req_level), .op0(req_op0), .op1(req_op1), .crn(req_crn),
        .crm(req_crm), .op2(req_op2), .host_mode(host_mode), .nest_bits(nest_bits),
        .trap_vm_rd(trap_vm_rd), .trap_vm_wr(trap_vm_wr), .fg_trap_rd(fg_trap_rd),
        .fg_trap_wr(fg_trap_wr), .fg_enable(fg_enable),
        .monitor_present(monitor_present), .kind(kind), .tgt(tgt)
    );

    hxc_view #(.ASID8(ASID8)) view_i (
        .clk(clk), .rst_n(rst_n), .host_mode(host_mode), .stored(hyp_q),
        .wdata(req_wdata), .rd_view(rd_view), .wr_next(wr_next),
        .eff_hwu_lo(eff_hwu_lo), .eff_hwu_hi(eff_hwu_hi),
        .eff_access(eff_access), .eff_dirty(eff_dirty)
    );

    hxc_regs regs_i (
        .clk(clk), .rst_n(rst_n), .hyp_we(hyp_we), .hyp_d(wr_next),
        .guest_we(guest_we), .guest_d(req_wdata), .hyp_q(hyp_q), .guest_q(guest_q)
    );

    // Write enables and read source from the decoded outcome.
    always_comb begin
        hyp_we   = kind[K_WR] && (tgt == TGT_HYP);
        guest_we = kind[K_WR] && (tgt == TGT_GUEST);
        mem_wr   = kind[K_MEM] && req_write;
        rd_sel   = (tgt == TGT_HYP) ? rd_view : guest_q;
        cfg_view = rd_view;
    end

    // Registered response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid      <= 1'b0;
            rsp_kind       <= '0;
            rsp_rdata      <= '0;
            rsp_class      <= '0;
            rsp_mem_offset <= '0;
            rsp_mem_write  <= 1'b0;
            rsp_mem_wdata  <= '0;
        end else begin
            rsp_valid      <= req_valid;
            rsp_kind       <= kind;
            rsp_rdata      <= kind[K_RD] ? rd_sel : '0;
            rsp_class      <= kind[K_TRAP] ? TRAP_CLASS : 6'd0;
            rsp_mem_offset <= kind[K_MEM] ? MEM_SLOT_OFF : 12'd0;
            rsp_mem_write  <= mem_wr;
            rsp_mem_wdata  <= mem_wr ? req_wdata : '0;
        end
    end

    a_r1_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r11_no_update: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (kind[K_TRAP] || kind[K_UNDEF])) |=> ($stable(hyp_q) && $stable(guest_q)));
    a_r7_guest_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && kind[K_MEM]) |=> $stable(guest_q));
    a_r3_trap_class: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind[K_TRAP]) |-> rsp_class == TRAP_CLASS);
endmodule

// File: tb/hyp_xlat_ctl_tb.sv
module hyp_xlat_ctl_tb_top;
    localparam logic [4:0] KRD = 5'b00001, KWR = 5'b00010, KTR = 5'b00100,
                           KUD = 5'b01000, KMEM = 5'b10000;
    localparam logic [2:0] HYP = 3'd4, ALI = 3'd0, BAD = 3'd3;

    typedef struct {
        logic [4:0]  kind;
        logic [63:0] rdata;
        logic [5:0]  cls;
        logic [11:0] off;
        logic [63:0] mwd;
        string       tag;
    } exp_t;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 0, req_write = 0;
    logic [1:0] req_level = 0, req_op0 = 2'd3;
    logic [2:0] req_op1 = 0, req_op2 = 3'd2;
    logic [3:0] req_crn = 4'd2, req_crm = 4'd0;
    logic [63:0] req_wdata = 0;
    logic host_mode = 0, trap_vm_rd = 0, trap_vm_wr = 0;
    logic fg_trap_rd = 0, fg_trap_wr = 0, fg_enable = 0, monitor_present = 1;
    logic [2:0] nest_bits = 0;
    logic rsp_valid, rsp_mem_write, eff_access, eff_dirty;
    logic [4:0] rsp_kind;
    logic [63:0] rsp_rdata, rsp_mem_wdata, cfg_view;
    logic [5:0] rsp_class;
    logic [11:0] rsp_mem_offset;
    logic [3:0] eff_hwu_lo, eff_hwu_hi;

    int checks = 0, fails = 0;
    bit done = 0;
    exp_t sb[$];

    always #5 clk = ~clk;

    hyp_xlat_ctl dut_i (.*);

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver: one request per cycle, expected outcome pushed to the scoreboard.
    task automatic acc(logic [1:0] lvl, logic wr, logic [2:0] op1, logic [63:0] wd,
                       logic [4:0] k, logic [63:0] rd, string tag);
        exp_t e;
        e.kind = k; e.rdata = rd; e.cls = (k == KTR) ? 6'h18 : 6'h0;
        e.off = (k == KMEM) ? 12'h120 : 12'h0;
        e.mwd = (k == KMEM && wr) ? wd : 64'h0; e.tag = tag;
        sb.push_back(e);
        req_valid = 1; req_write = wr; req_level = lvl; req_op1 = op1; req_wdata = wd;
        @(negedge clk);
        req_valid = 0;
        @(negedge clk);
    endtask

    // Monitor: compare each response against the oldest expected item.
    initial begin
        forever begin
            @(posedge clk); #2;
            if (rsp_valid) begin
                exp_t e;
                if (sb.size() == 0) begin
                    checks++; fails++;
                    $display("FAIL R1 unexpected response actual=1 expected=0");
                end else begin
                    e = sb.pop_front();
                    chk({e.tag, " kind"}, 64'(rsp_kind), 64'(e.kind));
                    chk({e.tag, " rdata"}, rsp_rdata, e.rdata);
                    chk({e.tag, " class"}, 64'(rsp_class), 64'(e.cls));
                    chk({e.tag, " offset"}, 64'(rsp_mem_offset), 64'(e.off));
                    chk({e.tag, " memwdata"}, rsp_mem_wdata, e.mwd);
                end
            end
        end
    end

    task automatic eff(string tag, logic [3:0] lo, logic [3:0] hi, logic a, logic d);
        chk({tag, " hwu_lo"}, 64'(eff_hwu_lo), 64'(lo));
        chk({tag, " hwu_hi"}, 64'(eff_hwu_hi), 64'(hi));
        chk({tag, " access"}, 64'(eff_access), 64'(a));
        chk({tag, " dirty"}, 64'(eff_dirty), 64'(d));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R8 reset rsp_valid", 64'(rsp_valid), 0);
        chk("R8 reset view", cfg_view, 64'h0000_0000_8080_0000);
        eff("R10 reset", 0, 0, 0, 0);

        // R1/R8: narrow-view all-ones write and read at levels 2 and 3
        acc(2, 1, HYP, '1, KWR, 0, "R1 wr");
        acc(2, 0, HYP, 0, KRD, 64'h0000_0000_FFF7_FF3F, "R8 rd L2");
        acc(3, 0, HYP, 0, KRD, 64'h0000_0000_FFF7_FF3F, "R1 rd L3");
        // R2: level 0
        acc(0, 0, HYP, 0, KUD, 0, "R2 rd");
        acc(0, 1, ALI, 0, KUD, 0, "R2 wr");
        // R3: level 1 to hypervisor encoding
        acc(1, 0, HYP, 0, KUD, 0, "R3 undef");
        nest_bits = 3'b001;
        acc(1, 0, HYP, 0, KTR, 0, "R3 trap");
        acc(1, 1, HYP, 0, KTR, 0, "R3 trap wr");
        nest_bits = 3'b000;
        acc(2, 0, HYP, 0, KRD, 64'h0000_0000_FFF7_FF3F, "R11 unchanged");
        // R12: unknown encoding
        acc(2, 0, BAD, 0, KUD, 0, "R12 bad op1");
        // R4/R9: alias routing and host view
        acc(2, 1, ALI, 64'h1234_5678_9ABC_DEF0, KWR, 0, "R4 guest wr");
        acc(1, 0, ALI, 0, KRD, 64'h1234_5678_9ABC_DEF0, "R4 guest rd");
        host_mode = 1;
        acc(2, 1, ALI, '1, KWR, 0, "R4 host alias wr");
        acc(2, 0, HYP, 0, KRD, 64'h07FF_FFF7_FFFF_FFBF, "R9 host rd");
        acc(3, 0, ALI, 0, KRD, 64'h1234_5678_9ABC_DEF0, "R4 L3 alias");
        eff("R10 host ones", 4'hF, 4'hF, 1, 1);
        // R10: narrow view gating
        host_mode = 0;
        @(negedge clk);
        eff("R10 narrow ones", 4'hF, 4'h0, 1, 1);
        acc(2, 1, HYP, 64'h0000_0000_1E40_0000, KWR, 0, "R10 wr");
        acc(2, 0, HYP, 0, KRD, 64'h0000_0000_9EC0_0000, "R8 rd2");
        eff("R10 narrow gated", 0, 0, 0, 0);
        host_mode = 1;
        acc(2, 0, HYP, 0, KRD, 64'h07FF_FFF7_9EC0_0000, "R8 upper kept");
        acc(2, 1, HYP, 64'h0007_FD00_0000_0000, KWR, 0, "R10 host wr");
        eff("R10 host gated", 4'h0, 4'hF, 0, 0);
        acc(2, 0, HYP, 0, KRD, 64'h0007_FD00_0000_0000, "R9 rd");
        host_mode = 0;
        // R5: trap-VM controls
        trap_vm_rd = 1;
        acc(1, 0, ALI, 0, KTR, 0, "R5 rd trap");
        acc(1, 1, ALI, 64'hAAAA, KWR, 0, "R5 wr ok");
        trap_vm_rd = 0; trap_vm_wr = 1;
        acc(1, 1, ALI, 64'h5555, KTR, 0, "R5 wr trap");
        acc(1, 0, ALI, 0, KRD, 64'hAAAA, "R11 guest kept");
        trap_vm_wr = 0;
        // R6: fine-grained gating
        fg_trap_rd = 1;
        acc(1, 0, ALI, 0, KRD, 64'hAAAA, "R6 gated off");
        fg_enable = 1;
        acc(1, 0, ALI, 0, KTR, 0, "R6 enabled");
        fg_enable = 0; monitor_present = 0;
        acc(1, 0, ALI, 0, KTR, 0, "R6 no monitor");
        monitor_present = 1; fg_trap_rd = 0; fg_trap_wr = 1; fg_enable = 1;
        acc(1, 1, ALI, 64'h7777, KTR, 0, "R6 wr trap");
        fg_trap_wr = 0; fg_enable = 0;
        // R7: memory redirect
        nest_bits = 3'b111;
        acc(1, 1, ALI, 64'hBEEF, KMEM, 0, "R7 mem wr");
        acc(1, 0, ALI, 0, KMEM, 0, "R7 mem rd");
        acc(1, 0, HYP, 0, KTR, 0, "R3 nest trap");
        trap_vm_rd = 1;
        acc(1, 0, ALI, 0, KTR, 0, "R7 trap first");
        trap_vm_rd = 0; nest_bits = 3'b011;
        acc(1, 0, ALI, 0, KRD, 64'hAAAA, "R7 guest kept");
        nest_bits = 0;

        repeat (3) @(negedge clk);
        chk("R1 scoreboard drained", 64'(sb.size()), 0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL R1 watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule